// File: doc/BRIEF.md
# Serial Flash Range Checksum Engine

This engine streams a run of bytes out of an external serial configuration flash and adds them into a 32-bit checksum, so the stored configuration and the flash wiring are both covered by one number. The host supplies a start byte address, a byte count and a start pulse. The engine then opens one SPI read transaction and keeps chip select low until the last byte of the run has arrived. A build-time switch also launches one run straight out of reset, using whatever address and length sit on the inputs at that moment. This is the check normally made at power-up.

The engine picks the read command itself. A run whose last byte lies below the 16 MB boundary uses the plain read with a 3-byte address. Any run that reaches past that boundary uses the read with a 4-byte address. The result stays on `sum_o` next to a `done_o` flag. `pass_o` compares the result against an expected value loaded by the host.

Top module: `flash_sum_engine`

## Requirements
- R1: The serial link is SPI mode 0. `spi_sck_o` is low whenever `spi_cs_no` is high. `spi_mosi_o` changes only while `spi_sck_o` is low. `spi_miso_i` is sampled on the rising edge of `spi_sck_o`. Every high phase and every low phase inside a byte lasts SCK_DIV/2 system cycles. SCK_DIV is an even value of at least 2.
- R2: Let end = addr_i + len_i. When end <= 2^24, the engine sends command byte 0x03 and then the low 24 address bits, as three bytes. When end > 2^24, it sends 0x13 and then the address zero-extended to 32 bits, as four bytes. All bytes go out MSB first.
- R3: A run with a nonzero length lowers `spi_cs_no` exactly once. Inside that one low period the engine produces exactly 8 x (header bytes + len_i) rising edges on `spi_sck_o`.
- R4: `sum_o` is the modulo-2^32 sum of all bytes read, starting from zero. Each byte is assembled from `spi_miso_i` with the MSB first.
- R5: When a start is accepted with len_i = 0, the next cycle shows `done_o`=1, `busy_o`=0 and `sum_o`=0, and `spi_cs_no` never goes low.
- R6: `busy_o` rises in the cycle after an accepted start and stays high until the last byte has been added. `done_o` then goes high and holds until the next accepted start. A `start_i` pulse while `busy_o` is high has no effect on the run in progress. `busy_o` and `done_o` are never high together.
- R7: `pass_o` is 1 exactly when `done_o` is 1 and `sum_o` equals `expect_i`.
- R8: When AUTO_START=1, exactly one run starts on the first cycle after reset is released. It uses the `addr_i` and `len_i` values present in that cycle.
- R9: While `rst_ni` is low: `busy_o`=0, `done_o`=0, `sum_o`=0, `spi_cs_no`=1 and `spi_sck_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; accepted only while idle |
| addr_i | input | ADDR_W (25) | First byte address of the range |
| len_i | input | LEN_W (26) | Number of bytes to read, 0 to 2^25 |
| expect_i | input | 32 | Expected checksum for the pass flag |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Last run has finished; held until next start |
| sum_o | output | 32 | Checksum result |
| pass_o | output | 1 | Result matches expect_i |
| spi_sck_o | output | 1 | SPI clock |
| spi_cs_no | output | 1 | SPI chip select, active low |
| spi_mosi_o | output | 1 | SPI data to flash |
| spi_miso_i | input | 1 | SPI data from flash |

## Verification
The bench drives the range boundary cases. The first is a range that ends exactly at 16 MB, where a wrong comparison would switch to the 4-byte command and shift the flash window by one address byte. The second is a range one byte longer, where staying on the 3-byte command would read the wrong bytes. The third is a range that ends at the 32 MB top. A flash model on the bench records the command, the address and the clock edges of each chip-select period. A design that dropped chip select between bytes, or sent an extra byte, would therefore show the wrong session or edge count. The bench also covers a zero-length start, where a faulty design would open a transaction or hang busy, and a start pulse in mid-run, where a design that accepted it would corrupt the sum. The power-up automatic run is checked as well.

// File: rtl/flash_sum_pkg.sv
package flash_sum_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_HDR, ST_DATA} fsum_state_e;
  localparam logic [7:0]  CMD_RD3     = 8'h03;
  localparam logic [7:0]  CMD_RD4     = 8'h13;
  localparam int unsigned NARROW_SPAN = 32'h0100_0000;
endpackage

// File: rtl/fsum_spi_byte.sv
module fsum_spi_byte #(
  parameter int SCK_DIV = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       go_i,
  input  logic [7:0] tx_i,
  input  logic       miso_i,
  output logic       sck_o,
  output logic       mosi_o,
  output logic [7:0] rx_o,
  output logic       done_o
);
  localparam int HALF  = SCK_DIV / 2;
  localparam int CNT_W = $clog2(HALF) + 1;

  logic             act_q, sck_q, done_q;
  logic [CNT_W-1:0] cnt_q;
  logic [2:0]       bit_q;
  logic [7:0]       tx_q, rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0; sck_q <= 1'b0; done_q <= 1'b0;
      cnt_q <= '0; bit_q <= '0; tx_q <= '0; rx_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (go_i) begin
        act_q <= 1'b1; sck_q <= 1'b0; cnt_q <= '0; bit_q <= '0; tx_q <= tx_i;
      end else if (act_q) begin
        if (cnt_q == CNT_W'(HALF - 1)) begin
          cnt_q <= '0;
          if (!sck_q) begin
            sck_q <= 1'b1;
            rx_q  <= {rx_q[6:0], miso_i};
          end else begin
            sck_q <= 1'b0;
            if (bit_q == 3'd7) begin
              act_q  <= 1'b0;
              done_q <= 1'b1;
            end else begin
              bit_q <= bit_q + 3'd1;
              tx_q  <= {tx_q[6:0], 1'b0};
            end
          end
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  assign sck_o  = sck_q;
  assign mosi_o = tx_q[7];
  assign rx_o   = rx_q;
  assign done_o = done_q;

  // R1: clock parked low outside a byte
  a_r1_sck_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_q |-> !sck_q);
  // R1: data bit held across the high phase
  a_r1_mosi_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_q && !go_i && act_q && !(cnt_q == CNT_W'(HALF - 1))) |=> $stable(mosi_o));
endmodule

// File: rtl/fsum_hdr_sel.sv
module fsum_hdr_sel #(
  parameter int ADDR_W = 25
) (
  input  logic [2:0]        idx_i,
  input  logic              wide_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [7:0]        byte_o
);
  import flash_sum_pkg::*;
  logic [31:0] addr32;
  logic [2:0]  last;

  assign addr32 = 32'(addr_i);
  assign last   = wide_i ? 3'd4 : 3'd3;

  always_comb begin
    if (idx_i == 3'd0)      byte_o = wide_i ? CMD_RD4 : CMD_RD3;
    else if (idx_i > last)  byte_o = 8'h00;
    else                    byte_o = 8'(addr32 >> (8 * (last - idx_i)));
  end
endmodule

// File: rtl/fsum_accum.sv
module fsum_accum (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        add_i,
  input  logic [7:0]  byte_i,
  output logic [31:0] sum_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sum_o <= '0;
    else if (clr_i)  sum_o <= '0;
    else if (add_i)  sum_o <= sum_o + 32'(byte_i);
  end
endmodule

// File: rtl/flash_sum_engine.sv
module flash_sum_engine #(
  parameter int ADDR_W     = 25,
  parameter int LEN_W      = ADDR_W + 1,
  parameter int SCK_DIV    = 2,
  parameter bit AUTO_START = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [31:0]       expect_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [31:0]       sum_o,
  output logic              pass_o,
  output logic              spi_sck_o,
  output logic              spi_cs_no,
  output logic              spi_mosi_o,
  input  logic              spi_miso_i
);
  import flash_sum_pkg::*;
  localparam int END_W = LEN_W + 1;

  fsum_state_e       st_q;
  logic              auto_q, fire, wide_q, wide_d, cs_nq, done_q;
  logic [2:0]        hdr_idx_q, sel_idx;
  logic              sel_wide;
  logic [LEN_W-1:0]  remain_q;
  logic [ADDR_W-1:0] addr_q;
  logic [END_W-1:0]  end_d;
  logic              go, bdone, add_en;
  logic [7:0]        tx_byte, rx_byte;

  assign end_d  = END_W'(addr_i) + END_W'(len_i);
  assign wide_d = end_d > END_W'(NARROW_SPAN);
  assign fire   = (start_i | auto_q) & (st_q == ST_IDLE);
  assign add_en = (st_q == ST_DATA) & bdone;

  always_comb begin
    go       = 1'b0;
    sel_idx  = 3'd0;
    sel_wide = wide_q;
    unique case (st_q)
      ST_IDLE: begin sel_wide = wide_d; go = fire && (len_i != '0); end
      ST_HDR:  begin sel_idx = hdr_idx_q + 3'd1; go = bdone; end
      ST_DATA: go = bdone && (remain_q != LEN_W'(1));
      default: ;
    endcase
  end

  fsum_hdr_sel #(.ADDR_W(ADDR_W)) u_hdr (
    .idx_i(sel_idx), .wide_i(sel_wide), .addr_i(addr_q), .byte_o(tx_byte));

  fsum_spi_byte #(.SCK_DIV(SCK_DIV)) u_spi (
    .clk_i(clk_i), .rst_ni(rst_ni), .go_i(go), .tx_i(tx_byte),
    .miso_i(spi_miso_i), .sck_o(spi_sck_o), .mosi_o(spi_mosi_o),
    .rx_o(rx_byte), .done_o(bdone));

  fsum_accum u_acc (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(fire), .add_i(add_en),
    .byte_i(rx_byte), .sum_o(sum_o));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; auto_q <= AUTO_START; hdr_idx_q <= '0; remain_q <= '0;
      wide_q <= 1'b0; addr_q <= '0; cs_nq <= 1'b1; done_q <= 1'b0;
    end else begin
      if (st_q == ST_IDLE) auto_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (fire) begin
          if (len_i == '0) begin
            done_q <= 1'b1;
          end else begin
            done_q    <= 1'b0;
            st_q      <= ST_HDR;
            hdr_idx_q <= '0;
            remain_q  <= len_i;
            wide_q    <= wide_d;
            addr_q    <= addr_i;
            cs_nq     <= 1'b0;
          end
        end
        ST_HDR: if (bdone) begin
          if (hdr_idx_q == (wide_q ? 3'd4 : 3'd3)) st_q <= ST_DATA;
          else hdr_idx_q <= hdr_idx_q + 3'd1;
        end
        ST_DATA: if (bdone) begin
          remain_q <= remain_q - LEN_W'(1);
          if (remain_q == LEN_W'(1)) begin
            st_q   <= ST_IDLE;
            cs_nq  <= 1'b1;
            done_q <= 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o    = (st_q != ST_IDLE);
  assign done_o    = done_q;
  assign spi_cs_no = cs_nq;
  assign pass_o    = done_q && (sum_o == expect_i);

  a_r3_cs_low_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !spi_cs_no);
  a_r1_sck_low_deselect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_cs_no |-> !spi_sck_o);
  a_r6_busy_done_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));
  a_r6_range_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(addr_q));
  a_r7_pass_needs_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_o |-> done_o);
  a_r5_zero_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && len_i == '0) |=> (done_o && !busy_o && sum_o == 32'd0 && spi_cs_no));
endmodule

// File: tb/tb_flash_sum_engine.sv
module tb_flash_sum_engine;
  localparam int ADDR_W = 25;
  localparam int LEN_W  = 26;
  localparam int DIV    = 4;
  localparam int NV     = 6;
  localparam logic [ADDR_W-1:0] V_ADDR [NV] = '{25'h0000000, 25'h0000100,
    25'h0ABCDEF, 25'h0FFFFF0, 25'h0FFFFF0, 25'h1FFFFC0};
  localparam int V_LEN [NV] = '{1, 16, 7, 16, 17, 64};

  logic clk = 0, rst_ni = 0, start_i = 0, miso = 0;
  logic [ADDR_W-1:0] addr_i = 25'h40;
  logic [LEN_W-1:0]  len_i  = 26'd9;
  logic [31:0] expect_i = 0, sum_o;
  logic busy_o, done_o, pass_o, sck, cs_n, mosi;
  int checks = 0, errors = 0, cyc = 0;

  always #5 clk = ~clk;

  flash_sum_engine #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .SCK_DIV(DIV), .AUTO_START(1'b1)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .addr_i(addr_i), .len_i(len_i),
    .expect_i(expect_i), .busy_o(busy_o), .done_o(done_o), .sum_o(sum_o), .pass_o(pass_o),
    .spi_sck_o(sck), .spi_cs_no(cs_n), .spi_mosi_o(mosi), .spi_miso_i(miso));

  function automatic logic [7:0] fdata(input logic [31:0] a);
    logic [31:0] t;
    t = a * 32'd37 + (a >> 8) + (a >> 16) * 32'd5 + 32'h5A;
    return t[7:0];
  endfunction

  // flash model
  int sess = 0, sess_seen = 0, nrise = 0;
  logic [7:0] cmd; logic [31:0] adr;
  always @(negedge cs_n) sess++;
  always @(posedge sck) if (!cs_n) begin
    if (sess != sess_seen) begin sess_seen = sess; nrise = 0; cmd = 0; adr = 0; end
    if (nrise < 8) cmd = {cmd[6:0], mosi};
    else if (nrise < ((cmd == 8'h13) ? 40 : 32)) adr = {adr[30:0], mosi};
    nrise++;
  end
  always @(negedge sck) if (!cs_n) begin
    int hdr, idx; logic [7:0] b;
    hdr = (cmd == 8'h13) ? 40 : 32;
    if (nrise >= hdr) begin
      idx = nrise - hdr;
      b = fdata(adr + 32'(idx / 8));
      miso = b[7 - idx % 8];
    end
  end

  // R1 line monitor
  logic p_sck = 0, p_mosi = 0; int hi_run = 0, lo_run = 0, r1_bad = 0;
  always @(negedge clk) begin
    if (rst_ni) begin
      if (cs_n && sck) r1_bad++;
      if (!cs_n && sck && p_sck && mosi != p_mosi) r1_bad++;
      if (sck) hi_run++;
      if (p_sck && !sck) begin if (hi_run != DIV / 2) r1_bad++; hi_run = 0; end
    end
    p_sck = sck; p_mosi = mosi;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++; $display("FAIL watchdog act=%0d exp=<150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors); $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s act=%0h exp=%0h", req, act, exp); end
  endtask

  function automatic logic [31:0] exp_sum(input logic [31:0] a, input int n);
    logic [31:0] s = 0;
    for (int i = 0; i < n; i++) s += 32'(fdata(a + 32'(i)));
    return s;
  endfunction

  task automatic wait_done();
    int to = 0;
    while (!done_o && to < 20000) begin @(negedge clk); to++; end
    chk(done_o, "R6 done reached", 32'(done_o), 1);
  endtask

  task automatic pulse_start();
    @(negedge clk) start_i = 1;
    @(negedge clk) start_i = 0;
  endtask

  task automatic check_run(input logic [31:0] a, input int n, input int s0);
    logic wide; logic [31:0] es;
    wide = (a + 32'(n)) > 32'h0100_0000;
    es = exp_sum(a, n);
    chk(sum_o == es, "R4 sum", sum_o, es);
    chk(cmd == (wide ? 8'h13 : 8'h03), "R2 command", 32'(cmd), wide ? 32'h13 : 32'h03);
    chk(adr == (wide ? a : (a & 32'hFFFFFF)), "R2 address", adr, a);
    chk(nrise == (wide ? 40 : 32) + 8 * n, "R3 edge count", nrise, (wide ? 40 : 32) + 8 * n);
    chk(sess == s0 + 1, "R3 single select", sess, s0 + 1);
    expect_i = es; #1;
    chk(pass_o == 1'b1, "R7 pass on match", 32'(pass_o), 1);
    expect_i = es + 1; #1;
    chk(pass_o == 1'b0, "R7 no pass on mismatch", 32'(pass_o), 0);
  endtask

  initial begin
    int s0;
    // R9 reset state
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && sum_o == 0 && cs_n && !sck, "R9 reset state",
        {busy_o, done_o, cs_n, sck}, 4'b0010);
    // R8 auto run uses inputs present at reset release
    rst_ni = 1;
    wait_done();
    check_run(32'h40, 9, 0);

    // vector table
    for (int v = 0; v < NV; v++) begin
      s0 = sess;
      addr_i = V_ADDR[v]; len_i = LEN_W'(V_LEN[v]);
      pulse_start();
      chk(busy_o && !done_o, "R6 busy after start", {busy_o, done_o}, 2'b10);
      wait_done();
      check_run(32'(V_ADDR[v]), V_LEN[v], s0);
    end

    // R6 done held
    repeat (10) @(negedge clk);
    chk(done_o && !busy_o, "R6 done held", {busy_o, done_o}, 2'b01);

    // R5 zero length
    s0 = sess; addr_i = 25'h123; len_i = 0;
    pulse_start();
    chk(done_o && !busy_o && sum_o == 0, "R5 zero length", sum_o, 0);
    repeat (20) @(negedge clk);
    chk(sess == s0 && cs_n, "R5 no select", sess, s0);

    // R6 start while busy ignored
    s0 = sess; addr_i = 25'h2000; len_i = 12;
    pulse_start();
    repeat (25) @(negedge clk);
    addr_i = 25'h5555; len_i = 3;
    pulse_start();
    addr_i = 25'h0; len_i = 0;
    wait_done();
    check_run(32'h2000, 12, s0);

    chk(r1_bad == 0, "R1 mode 0 timing", r1_bad, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule